// File: doc/BRIEF.md
# Buffered Serial Flash Sector Sequencer

This block sits on the host side of a serial flash that stages whole sectors through two on-chip buffers. A requester gives one of two operations: read a sector or write a sector. The request also names the sector and picks buffer 0 or 1. The sequencer then runs the full chain of SPI commands. Each command has its own chip-select window, and the block drives every bit through a small internal mode-0 shifter.

On a read, the block polls the device status until it is idle and asks the device to copy the sector into the chosen buffer. It then polls again, checks the two integrity bits and streams the buffer contents out. On a write, the block enables writing, polls until idle and pushes one sector's worth of bytes from the write stream through the chosen buffer. A configuration input decides whether a write-disable command follows. Each operation ends with a one-cycle done pulse, which carries an error flag and a code.

Both byte streams use valid/ready. While a stream cannot move, the SPI clock stops. A busy device is retried only up to a limit given on an input, after which the operation ends with a timeout error.

Top module: `sec_seq`

## Requirements
- R1: Once reset is released, chip select is high, the SPI clock is low, `req_ready` is high, and `done`, `err`, `rd_valid` and `wr_ready` are all low.
- R2: A read sends its commands in this order. First, status 0x84 is sent and then repeated for as long as the device reports busy. Next comes 0x5C (buffer 0) or 0x5D (buffer 1), followed by the sector number as two bytes, most significant byte first. Status is then polled again in the same way. Last comes 0x71 (buffer 0) or 0x73 (buffer 1), followed by two zero bytes and then `SECTOR_BYTES` bytes read from the device, which appear on the read stream.
- R3: A write sends its commands in this order: 0x06, then the status poll, then 0xF6 (buffer 0) or 0x98 (buffer 1), then the sector number as two bytes with the most significant byte first, then exactly `SECTOR_BYTES` bytes taken from the write stream. After that comes 0x04, but only if `cfg_wr_disable` was high when the request was accepted.
- R4: Every command sits in its own chip-select-low window, and chip select goes high between any two commands. The SPI clock stays low whenever chip select is high.
- R5: The SPI link runs in mode 0. Bytes go out most significant bit first. MOSI changes only while SCK is low, and MISO is captured on the rising SCK edge. SCK stays high for exactly one system clock.
- R6: A status response is two bytes. The first byte holds bits 15..8, and the device is busy if any of bits 15, 14 or 13 is set. Bits 1 and 0 are the integrity bits.
- R7: On the poll that follows the buffer transfer of a read, a ready response with either integrity bit set ends the operation with `err`=1 and `err_code`=2. In that case no buffer-read command is sent and `rd_valid` never rises. The integrity bits in the first poll of a read have no effect.
- R8: A busy response ends the operation with `err`=1 and `err_code`=1 when it is the `poll_limit`-th busy response of the current poll phase. A limit of 0 counts as 1. No further command follows a timeout.
- R9: While `rd_valid` is high and `rd_ready` is low, `rd_data` holds its value and SCK stays low.
- R10: During the write payload, a low `wr_valid` stops SCK after the byte in flight. Each byte is accepted when `wr_valid` and `wr_ready` are both high at a clock edge.
- R11: `done` lasts exactly one cycle. `err` and `err_code` are non-zero only together with `done`. A successful operation reports `err`=0 and `err_code`=0.
- R12: A request is taken only while `req_ready` is high, and `req_ready` stays low from acceptance until the operation finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_write | input | 1 | 1 = sector write, 0 = sector read |
| req_buf | input | 1 | Buffer select (0 or 1) |
| req_sector | input | SEC_W | Sector number |
| cfg_wr_disable | input | 1 | Send write disable after a write |
| poll_limit | input | POLL_W | Busy responses allowed per poll phase |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte available |
| wr_ready | output | 1 | Write stream byte taken |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read stream byte available |
| rd_ready | input | 1 | Read stream consumer ready |
| done | output | 1 | Operation finished (one cycle) |
| err | output | 1 | Operation failed, valid with done |
| err_code | output | 2 | 0 none, 1 poll timeout, 2 integrity, valid with done |
| spi_csn | output | 1 | Chip select, active low |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |

## Verification
The assertions check, on every cycle, the properties that hold cycle by cycle. The SPI clock is quiet while chip select is high. A high phase of SCK lasts one cycle. The shifter never restarts while busy. A held read byte stays stable. `done` is a single-cycle pulse that carries any error. The poll counter never runs past its limit. A bus-functional device model in the bench shows what the assertions cannot: the complete order of opcodes for each flow and both buffers, address and payload bytes landing at the right positions, timeout at the exact poll count (including a limit of zero), and a read cut short by the integrity bits. Back-pressure stalls on both streams are exercised against queued expected data.

// File: rtl/sec_pkg.sv
package sec_pkg;

  typedef enum logic [2:0] {
    C_WEN, C_STAT, C_XFER, C_RDBUF, C_WRBUF, C_WDIS
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_SHIFT, S_OUT, S_END
  } st_e;

  localparam logic [1:0] E_NONE    = 2'd0;
  localparam logic [1:0] E_TIMEOUT = 2'd1;
  localparam logic [1:0] E_INTEG   = 2'd2;

  function automatic logic [7:0] op_of(input cmd_e c, input logic b);
    logic [7:0] o;
    case (c)
      C_WEN:   o = 8'h06;
      C_STAT:  o = 8'h84;
      C_XFER:  o = b ? 8'h5D : 8'h5C;
      C_RDBUF: o = b ? 8'h73 : 8'h71;
      C_WRBUF: o = b ? 8'h98 : 8'hF6;
      default: o = 8'h04;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/sec_spi_shift.sv
module sec_spi_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx
);

  logic [7:0] sh_q, sh_d, rx_q, rx_d;
  logic [2:0] cnt_q, cnt_d;
  logic       sck_q, sck_d, busy_q, busy_d, done_q, done_d;

  always_comb begin
    sh_d   = sh_q;
    rx_d   = rx_q;
    cnt_d  = cnt_q;
    sck_d  = sck_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start) begin
      sh_d   = tx;
      cnt_d  = 3'd0;
      sck_d  = 1'b0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (!sck_q) begin
        sck_d = 1'b1;
        rx_d  = {rx_q[6:0], miso};
      end else begin
        sck_d = 1'b0;
        sh_d  = {sh_q[6:0], 1'b0};
        cnt_d = cnt_q + 3'd1;
        if (cnt_q == 3'd7) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      sck_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      cnt_q  <= cnt_d;
      sck_q  <= sck_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign sck  = sck_q;
  assign mosi = sh_q[7];
  assign busy = busy_q;
  assign done = done_q;
  assign rx   = rx_q;

  // R5
  sck_high_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |=> !sck_q);

  // R5
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !sck_q && !start) |=> $stable(mosi));

endmodule

// File: rtl/sec_poll_track.sv
module sec_poll_track #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          bump,
  input  logic [CW-1:0] limit,
  output logic          expire
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   eff;

  assign eff    = (limit == '0) ? (CW+1)'(1) : {1'b0, limit};
  assign expire = ({1'b0, cnt_q} + (CW+1)'(1)) >= eff;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (bump) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8
  poll_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bump |-> !expire);

endmodule

// File: rtl/sec_seq.sv
module sec_seq
  import sec_pkg::*;
#(
  parameter int SECTOR_BYTES = 522,
  parameter int SEC_W        = 16,
  parameter int POLL_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_buf,
  input  logic [SEC_W-1:0]  req_sector,
  input  logic              cfg_wr_disable,
  input  logic [POLL_W-1:0] poll_limit,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code,
  output logic              spi_csn,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  localparam int BI_W      = $clog2(SECTOR_BYTES + 3) + 1;
  localparam int LAST_DATA = SECTOR_BYTES + 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  st_e             st_q, st_d;
  cmd_e            cmd_q, cmd_d;
  logic [BI_W-1:0] bidx_q, bidx_d, last_idx;
  logic [2:0]      busyb_q, busyb_d;
  logic [1:0]      di_q, di_d;
  logic            post_q, post_d, wr_q, wr_d, buf_q, buf_d, wdis_q, wdis_d;
  logic [15:0]     sec_q, sec_d;
  logic            done_q, done_d, err_q, err_d;
  logic [1:0]      code_q, code_d;
  logic            rdv_q, rdv_d;
  logic [7:0]      rdd_q, rdd_d;

  logic            sh_start, sh_busy, sh_done, wr_take;
  logic [7:0]      sh_tx, sh_rx;
  logic            poll_clr, poll_bump, poll_expire;
  logic            payload;

  sec_spi_shift u_shift (
    .clk   (clk),
    .rst_n (rst_i),
    .start (sh_start),
    .tx    (sh_tx),
    .miso  (spi_miso),
    .sck   (spi_sck),
    .mosi  (spi_mosi),
    .busy  (sh_busy),
    .done  (sh_done),
    .rx    (sh_rx)
  );

  sec_poll_track #(.CW(POLL_W)) u_poll (
    .clk    (clk),
    .rst_n  (rst_i),
    .clr    (poll_clr),
    .bump   (poll_bump),
    .limit  (poll_limit),
    .expire (poll_expire)
  );

  assign payload = (bidx_q >= BI_W'(3));

  always_comb begin
    case (cmd_q)
      C_WEN, C_WDIS:   last_idx = '0;
      C_STAT, C_XFER:  last_idx = BI_W'(2);
      default:         last_idx = BI_W'(LAST_DATA);
    endcase
  end

  // byte placed on the wire for the current frame position
  always_comb begin
    sh_tx = 8'h00;
    if (bidx_q == '0) begin
      sh_tx = op_of(cmd_q, buf_q);
    end else if (cmd_q == C_XFER || cmd_q == C_WRBUF) begin
      if (bidx_q == BI_W'(1))      sh_tx = sec_q[15:8];
      else if (bidx_q == BI_W'(2)) sh_tx = sec_q[7:0];
      else                         sh_tx = wr_data;
    end
  end

  always_comb begin
    st_d      = st_q;
    cmd_d     = cmd_q;
    bidx_d    = bidx_q;
    busyb_d   = busyb_q;
    di_d      = di_q;
    post_d    = post_q;
    wr_d      = wr_q;
    buf_d     = buf_q;
    wdis_d    = wdis_q;
    sec_d     = sec_q;
    done_d    = 1'b0;
    err_d     = 1'b0;
    code_d    = E_NONE;
    rdv_d     = rdv_q;
    rdd_d     = rdd_q;
    sh_start  = 1'b0;
    wr_take   = 1'b0;
    poll_clr  = 1'b0;
    poll_bump = 1'b0;

    case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          wr_d     = req_write;
          buf_d    = req_buf;
          wdis_d   = cfg_wr_disable;
          sec_d    = 16'(req_sector);
          post_d   = 1'b0;
          cmd_d    = req_write ? C_WEN : C_STAT;
          bidx_d   = '0;
          poll_clr = 1'b1;
          st_d     = S_LOAD;
        end
      end

      S_LOAD: begin
        if (cmd_q == C_WRBUF && payload) begin
          if (wr_valid) begin
            wr_take  = 1'b1;
            sh_start = 1'b1;
            st_d     = S_SHIFT;
          end
        end else begin
          sh_start = 1'b1;
          st_d     = S_SHIFT;
        end
      end

      S_SHIFT: begin
        if (sh_done) begin
          if (cmd_q == C_STAT && bidx_q == BI_W'(1)) busyb_d = sh_rx[7:5];
          if (cmd_q == C_STAT && bidx_q == BI_W'(2)) di_d    = sh_rx[1:0];
          if (cmd_q == C_RDBUF && payload) begin
            rdv_d = 1'b1;
            rdd_d = sh_rx;
            st_d  = S_OUT;
          end else if (bidx_q == last_idx) begin
            st_d = S_END;
          end else begin
            bidx_d = bidx_q + BI_W'(1);
            st_d   = S_LOAD;
          end
        end
      end

      S_OUT: begin
        if (rd_ready) begin
          rdv_d = 1'b0;
          if (bidx_q == last_idx) begin
            st_d = S_END;
          end else begin
            bidx_d = bidx_q + BI_W'(1);
            st_d   = S_LOAD;
          end
        end
      end

      default: begin  // S_END: chip select high for this cycle
        bidx_d = '0;
        st_d   = S_LOAD;
        case (cmd_q)
          C_WEN: begin
            cmd_d    = C_STAT;
            poll_clr = 1'b1;
          end
          C_STAT: begin
            if (|busyb_q) begin
              if (poll_expire) begin
                st_d   = S_IDLE;
                done_d = 1'b1;
                err_d  = 1'b1;
                code_d = E_TIMEOUT;
              end else begin
                poll_bump = 1'b1;
              end
            end else if (post_q) begin
              if (|di_q) begin
                st_d   = S_IDLE;
                done_d = 1'b1;
                err_d  = 1'b1;
                code_d = E_INTEG;
              end else begin
                cmd_d = C_RDBUF;
              end
            end else begin
              cmd_d = wr_q ? C_WRBUF : C_XFER;
            end
          end
          C_XFER: begin
            cmd_d    = C_STAT;
            post_d   = 1'b1;
            poll_clr = 1'b1;
          end
          C_WRBUF: begin
            if (wdis_q) begin
              cmd_d = C_WDIS;
            end else begin
              st_d   = S_IDLE;
              done_d = 1'b1;
            end
          end
          default: begin
            st_d   = S_IDLE;
            done_d = 1'b1;
          end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q    <= S_IDLE;
      cmd_q   <= C_STAT;
      bidx_q  <= '0;
      busyb_q <= '0;
      di_q    <= '0;
      post_q  <= 1'b0;
      wr_q    <= 1'b0;
      buf_q   <= 1'b0;
      wdis_q  <= 1'b0;
      sec_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= E_NONE;
      rdv_q   <= 1'b0;
      rdd_q   <= '0;
    end else begin
      st_q    <= st_d;
      cmd_q   <= cmd_d;
      bidx_q  <= bidx_d;
      busyb_q <= busyb_d;
      di_q    <= di_d;
      post_q  <= post_d;
      wr_q    <= wr_d;
      buf_q   <= buf_d;
      wdis_q  <= wdis_d;
      sec_q   <= sec_d;
      done_q  <= done_d;
      err_q   <= err_d;
      code_q  <= code_d;
      rdv_q   <= rdv_d;
      rdd_q   <= rdd_d;
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign spi_csn   = !(st_q == S_LOAD || st_q == S_SHIFT || st_q == S_OUT);
  assign wr_ready  = wr_take;
  assign rd_valid  = rdv_q;
  assign rd_data   = rdd_q;
  assign done      = done_q;
  assign err       = err_q;
  assign err_code  = code_q;

  // R4
  sck_cs_chk: assert property (@(posedge clk) disable iff (!rst_i)
    spi_csn |-> !spi_sck);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_i)
    done |=> !done);

  // R11
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (err || err_code != 2'd0) |-> done);

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R9
  rd_sck_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i)
    rd_valid |-> !spi_sck);

  // R12
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (req_valid && req_ready) |=> !req_ready);

  // R10
  wr_take_chk: assert property (@(posedge clk) disable iff (!rst_i)
    wr_ready |-> (wr_valid && !spi_csn && !sh_busy));

endmodule

// File: tb/sec_seq_test.sv
module sec_seq_test;

  localparam int SB = 522;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_write, req_buf, cfg_wr_disable;
  logic [15:0] req_sector;
  logic [7:0] poll_limit;
  logic [7:0] wr_data;
  logic       wr_valid, rd_ready;
  logic       req_ready, wr_ready, rd_valid, done, err;
  logic [7:0] rd_data;
  logic [1:0] err_code;
  logic       spi_csn, spi_sck, spi_mosi, spi_miso;

  always #10 clk = ~clk;

  sec_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_buf(req_buf), .req_sector(req_sector),
    .cfg_wr_disable(cfg_wr_disable), .poll_limit(poll_limit),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .done(done), .err(err), .err_code(err_code),
    .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rpat(input int sec, input int i);
    return 8'((sec * 13) + (i * 7) + (i >> 4));
  endfunction

  function automatic logic [7:0] wpat(input int sec, input int i);
    return 8'((i * 5) ^ sec ^ (i >> 3));
  endfunction

  // ---------------- device model ----------------
  logic [7:0] fbuf [0:1][0:SB-1];
  logic [7:0] op_log [$];
  int         busy_left = 0;
  logic [1:0] integ = 2'b00;
  int         stat_reads = 0;
  bit         frame_open = 0;
  int         bitc, byte_n;
  logic [7:0] inb, outsh, opc;
  logic [15:0] cur_stat, addr;
  int         wr_cnt, wr_cnt_last, xfer_addr, wr_addr;
  bit         wen_flag = 0, wen_at_write;
  int         sck_cs_bad = 0;

  function automatic logic [7:0] next_out(input int idx);
    if (opc == 8'h84 && idx == 1) return cur_stat[15:8];
    if (opc == 8'h84 && idx == 2) return cur_stat[7:0];
    if ((opc == 8'h71 || opc == 8'h73) && idx >= 3 && idx - 3 < SB)
      return fbuf[opc == 8'h73][idx - 3];
    return 8'h00;
  endfunction

  always @(negedge spi_csn) begin
    frame_open = 1; bitc = 0; byte_n = 0; wr_cnt = 0; opc = 8'h00;
  end

  always @(posedge spi_sck) begin
    if (spi_csn) sck_cs_bad++;
    else begin
      inb = {inb[6:0], spi_mosi};
      bitc++;
      if (bitc == 8) begin
        bitc = 0;
        if (byte_n == 0) begin
          opc = inb;
          op_log.push_back(inb);
          if (inb == 8'h84) begin
            cur_stat = {14'd0, integ};
            if (busy_left > 0) begin
              cur_stat = cur_stat | (16'h2000 << (stat_reads % 3));
              busy_left--;
            end
            stat_reads++;
          end
          if (inb == 8'hF6 || inb == 8'h98) wen_at_write = wen_flag;
        end else if (byte_n == 1) addr[15:8] = inb;
        else if (byte_n == 2) addr[7:0] = inb;
        else if ((opc == 8'hF6 || opc == 8'h98) && byte_n - 3 < SB) begin
          fbuf[opc == 8'h98][byte_n - 3] = inb;
          wr_cnt++;
        end
        byte_n++;
      end
    end
  end

  always @(negedge spi_sck) begin
    if (!spi_csn) begin
      if (bitc == 0) begin
        outsh = next_out(byte_n);
      end
      spi_miso = outsh[7];
      outsh = {outsh[6:0], 1'b0};
    end
  end

  always @(posedge spi_csn) begin
    if (frame_open) begin
      frame_open = 0;
      if (opc == 8'h06) wen_flag = 1;
      if (opc == 8'h04) wen_flag = 0;
      if (opc == 8'h5C || opc == 8'h5D) begin
        xfer_addr = int'(addr);
        for (int i = 0; i < SB; i++) fbuf[opc == 8'h5D][i] = rpat(int'(addr), i);
      end
      if (opc == 8'hF6 || opc == 8'h98) begin
        wr_cnt_last = wr_cnt;
        wr_addr = int'(addr);
      end
    end
  end

  // ---------------- read stream scoreboard ----------------
  logic [7:0] exp_rd [$];
  int rd_beats = 0, rd_mism = 0, rd_stall_bad = 0;
  bit stall_mode = 0;

  initial begin
    rd_ready = 1'b1;
    forever begin
      @(negedge clk);
      rd_ready = stall_mode ? ($urandom_range(0, 3) == 0) : 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid && !rd_ready && spi_sck) rd_stall_bad++;
      if (rd_valid && rd_ready) begin
        rd_beats++;
        if (exp_rd.size() == 0) rd_mism++;
        else begin
          logic [7:0] e;
          e = exp_rd.pop_front();
          if (e !== rd_data) rd_mism++;
        end
      end
    end
  end

  // ---------------- drivers ----------------
  int wr_stall_bad = 0;

  task automatic feed_write(input int sec, input bit gaps);
    for (int i = 0; i < SB; i++) begin
      if (gaps && (i % 100) == 50) begin
        wr_valid = 1'b0;
        for (int g = 0; g < 40; g++) begin
          @(negedge clk);
          if (g >= 30 && spi_sck) wr_stall_bad++;
        end
      end
      wr_data  = wpat(sec, i);
      wr_valid = 1'b1;
      #1;
      while (!wr_ready) begin
        @(negedge clk);
        #1;
      end
      @(negedge clk);
    end
    wr_valid = 1'b0;
  endtask

  logic [1:0] got_code;
  bit         got_err, ready_mid;

  task automatic run_op(input bit wr, input bit b, input int sec,
                        input bit wdis, input int lim);
    @(negedge clk);
    req_write = wr; req_buf = b; req_sector = 16'(sec);
    cfg_wr_disable = wdis; poll_limit = 8'(lim);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ready_mid = req_ready;
    while (!done) @(negedge clk);
    got_err = err; got_code = err_code;
    @(negedge clk);
    chk(done == 1'b0, "R11", "done one cycle", done, 0);
  endtask

  task automatic chk_ops(input string req, input logic [7:0] exp [$]);
    chk(op_log.size() == exp.size(), req, "command count", op_log.size(), exp.size());
    for (int i = 0; i < exp.size() && i < op_log.size(); i++)
      chk(op_log[i] == exp[i], req, $sformatf("opcode %0d", i), op_log[i], exp[i]);
    op_log.delete();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    logic [7:0] e [$];
    int bad;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_buf = 1'b0;
    req_sector = '0; cfg_wr_disable = 1'b0; poll_limit = 8'd20;
    wr_data = '0; wr_valid = 1'b0; spi_miso = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(spi_csn == 1'b1, "R1", "csn", spi_csn, 1);
    chk(spi_sck == 1'b0, "R1", "sck", spi_sck, 0);
    chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    chk(done == 1'b0 && err == 1'b0, "R1", "done/err", {done, err}, 0);
    chk(rd_valid == 1'b0 && wr_ready == 1'b0, "R1", "stream flags", {rd_valid, wr_ready}, 0);

    // R2 R5 plain read, buffer 0
    for (int i = 0; i < SB; i++) exp_rd.push_back(rpat(16'h0123, i));
    rd_beats = 0; rd_mism = 0;
    run_op(1'b0, 1'b0, 16'h0123, 1'b0, 20);
    e = '{8'h84, 8'h5C, 8'h84, 8'h71};
    chk_ops("R2", e);
    chk(xfer_addr == 16'h0123, "R2", "transfer sector", xfer_addr, 16'h0123);
    chk(rd_beats == SB, "R2", "read bytes", rd_beats, SB);
    chk(rd_mism == 0, "R5", "read data mismatches", rd_mism, 0);
    chk(got_err == 0 && got_code == 0, "R11", "success code", got_code, 0);

    // R6 R9 R12 read buffer 1, busy polls, consumer stalls
    busy_left = 3; stall_mode = 1; rd_beats = 0; rd_mism = 0; rd_stall_bad = 0;
    for (int i = 0; i < SB; i++) exp_rd.push_back(rpat(16'h0456, i));
    run_op(1'b0, 1'b1, 16'h0456, 1'b0, 20);
    stall_mode = 0;
    e = '{8'h84, 8'h84, 8'h84, 8'h84, 8'h5D, 8'h84, 8'h73};
    chk_ops("R6", e);
    chk(ready_mid == 1'b0, "R12", "req_ready during op", ready_mid, 0);
    chk(rd_beats == SB && rd_mism == 0, "R9", "stalled read data", rd_mism, 0);
    chk(rd_stall_bad == 0, "R9", "sck during read stall", rd_stall_bad, 0);

    // R3 R10 write buffer 0 with disable, producer gaps
    wr_stall_bad = 0;
    fork
      run_op(1'b1, 1'b0, 16'h0012, 1'b1, 20);
      feed_write(16'h0012, 1'b1);
    join
    e = '{8'h06, 8'h84, 8'hF6, 8'h04};
    chk_ops("R3", e);
    chk(wr_cnt_last == SB, "R3", "payload bytes", wr_cnt_last, SB);
    chk(wr_addr == 16'h0012, "R3", "write sector", wr_addr, 16'h0012);
    chk(wen_at_write == 1, "R3", "enabled before write", wen_at_write, 1);
    chk(wen_flag == 0, "R3", "disabled after write", wen_flag, 0);
    bad = 0;
    for (int i = 0; i < SB; i++) if (fbuf[0][i] !== wpat(16'h0012, i)) bad++;
    chk(bad == 0, "R10", "written bytes mismatches", bad, 0);
    chk(wr_stall_bad == 0, "R10", "sck during write gap", wr_stall_bad, 0);

    // R3 write buffer 1, no disable, one busy poll
    busy_left = 1;
    fork
      run_op(1'b1, 1'b1, 16'h0777, 1'b0, 20);
      feed_write(16'h0777, 1'b0);
    join
    e = '{8'h06, 8'h84, 8'h84, 8'h98};
    chk_ops("R3", e);
    bad = 0;
    for (int i = 0; i < SB; i++) if (fbuf[1][i] !== wpat(16'h0777, i)) bad++;
    chk(bad == 0, "R3", "buffer 1 bytes mismatches", bad, 0);
    chk(wen_flag == 1, "R3", "write left enabled", wen_flag, 1);

    // R8 timeout on read, limit 3
    busy_left = 10; rd_beats = 0;
    run_op(1'b0, 1'b0, 16'h0042, 1'b0, 3);
    e = '{8'h84, 8'h84, 8'h84};
    chk_ops("R8", e);
    chk(got_err == 1 && got_code == 2'd1, "R8", "timeout code", got_code, 1);

    // R8 limit 0 behaves as 1, write flow
    busy_left = 5;
    run_op(1'b1, 1'b0, 16'h0042, 1'b0, 0);
    e = '{8'h06, 8'h84};
    chk_ops("R8", e);
    chk(got_err == 1 && got_code == 2'd1, "R8", "limit 0 code", got_code, 1);
    busy_left = 0;

    // R7 integrity failure after transfer, no data streamed
    integ = 2'b10; rd_beats = 0;
    run_op(1'b0, 1'b0, 16'h0099, 1'b0, 20);
    e = '{8'h84, 8'h5C, 8'h84};
    chk_ops("R7", e);
    chk(got_err == 1 && got_code == 2'd2, "R7", "integrity code", got_code, 2);
    chk(rd_beats == 0, "R7", "bytes streamed", rd_beats, 0);
    integ = 2'b00;

    // R4 clock quiet while deselected
    chk(sck_cs_bad == 0, "R4", "sck edges with csn high", sck_cs_bad, 0);
    chk(spi_csn == 1'b1 && req_ready == 1'b1, "R4", "idle after ops", spi_csn, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule